// File: doc/BRIEF.md
# MII Nibble Transmitter

This block turns a byte-wide frame stream into the 4-bit transmit side of a media-independent interface. It runs entirely on the transmit clock supplied by the PHY. The same logic serves 100 Mb/s at 25 MHz and 10 Mb/s at 2.5 MHz.

Upstream logic offers bytes on a valid/ready stream. Each byte carries a start-of-frame and an end-of-frame marker. When a start-of-frame byte appears, the block first emits the preamble and the start-of-frame delimiter on its own. It then sends each payload byte as two nibbles, low nibble first, while holding the transmit enable high.

A collision input from the PHY is asynchronous. It is synchronized before use. In half-duplex mode it aborts the frame in flight and raises a one-cycle flag. In full-duplex mode it is ignored. Frame check sequence generation, backoff and retry timing, and the receive path are handled elsewhere.

Top module: `mii_nibble_tx`

## Requirements
- R1: After reset, txen and txd are 0, col_abort is 0, and s_ready is 0 while s_valid is low.
- R2: A frame opens with fifteen nibbles of 0x5 followed by one nibble of 0xD. This is seven 0x55 bytes and the 0xD5 delimiter, each sent low nibble first. txen rises in the same cycle as the first 0x5 nibble.
- R3: Each payload byte appears on txd as bits [3:0] in one cycle, then bits [7:4] in the next cycle, with txd[0] as the least significant bit.
- R4: For an N-byte frame closed by s_eof, txen stays high for exactly 16+2N consecutive cycles. It is low in the cycle after the final nibble.
- R5: While no frame is running, a byte offered without s_sof is accepted (s_ready=1) and discarded, and txen stays low. s_ready is never high while s_valid is low.
- R6: If s_valid is low when the next payload byte is due (the cycle that shows the high nibble of the current byte), the frame ends after the current byte.
- R7: If a byte with s_sof is offered when the next payload byte is due, the current frame ends without consuming that byte. After one cycle with txen low, that byte starts a new frame.
- R8: In half-duplex mode (full_duplex=0), a collision during a frame drops txen on the third rising edge after col_in rises. col_abort is high for exactly one cycle. The rest of the frame's bytes are then discarded as in R5.
- R9: In half-duplex mode, while the synchronized collision is high, no frame starts. A pending s_sof byte sees s_ready=0.
- R10: In full-duplex mode, col_in has no effect: frames complete intact and col_abort stays 0.
- R11: txd is 0 in every cycle in which txen is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Transmit clock from the PHY |
| tx_rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| full_duplex | input | 1 | 1 = full duplex (collision ignored), 0 = half duplex |
| col_in | input | 1 | Asynchronous collision indication from the PHY |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream byte accepted this cycle |
| s_data | input | 8 | Stream byte |
| s_sof | input | 1 | Byte is the first of a frame |
| s_eof | input | 1 | Byte is the last of a frame |
| txd | output | 4 | Transmit nibble |
| txen | output | 1 | Transmit enable, high over every frame nibble |
| col_abort | output | 1 | One-cycle pulse when a frame is aborted by a collision |

## Verification
The assertions check the following on every cycle:
- txd reads zero whenever txen is low.
- Every rising txen comes with a 0x5 nibble.
- The abort flag is a single-cycle pulse with txen low.
- Full duplex never produces an abort.
- No frame starts under a half-duplex collision.
- s_ready only answers a valid byte.

The exact nibble sequence, frame lengths, low-then-high nibble order, truncation on an upstream gap or an early start-of-frame, and the three-edge collision latency can only be shown by the bench. It rebuilds each frame from the pins and compares it with one computed from the bytes it sent.

// File: rtl/mnt_pkg.sv
package mnt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_DATA = 2'd2
  } mnt_state_e;

  localparam int          BYTE_W  = 8;
  localparam int          NIB_W   = 4;
  localparam logic [3:0]  NIB_PRE = 4'h5;
  localparam logic [3:0]  NIB_SFD = 4'hD;
endpackage

// File: rtl/mnt_rst_sync.sv
module mnt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = chain_q[STAGES-1];
endmodule

// File: rtl/mnt_sync.sv
module mnt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_async};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/mnt_tx_ctrl.sv
module mnt_tx_ctrl
  import mnt_pkg::*;
#(
  parameter int PRE_BYTES = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              full_duplex,
  input  logic              col_sync,
  input  logic              s_valid,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              s_sof,
  input  logic              s_eof,
  output logic              s_ready,
  output logic [NIB_W-1:0]  txd,
  output logic              txen,
  output logic              col_abort
);
  localparam int             PRE_NIB  = 2 * (PRE_BYTES + 1);
  localparam int             CNT_W    = $clog2(PRE_NIB);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PRE_NIB - 1);

  mnt_state_e        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] byte_q, byte_d;
  logic              hi_q, hi_d;
  logic              last_q, last_d;
  logic [NIB_W-1:0]  txd_q, txd_d;
  logic              txen_q, txen_d;
  logic              abort_q, abort_d;
  logic              col_hit;
  logic              load_en;

  assign col_hit = col_sync && !full_duplex;

  // next-state logic
  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    hi_d    = hi_q;
    last_d  = last_q;
    load_en = 1'b0;
    s_ready = 1'b0;
    abort_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (s_valid && !s_sof) begin
          s_ready = 1'b1;
        end else if (s_valid && s_sof && !col_hit) begin
          st_d  = ST_PRE;
          cnt_d = '0;
        end
      end
      ST_PRE: begin
        if (col_hit) begin
          st_d    = ST_IDLE;
          abort_d = 1'b1;
        end else if (cnt_q == CNT_LAST) begin
          if (s_valid) begin
            s_ready = 1'b1;
            load_en = 1'b1;
            st_d    = ST_DATA;
          end else begin
            st_d = ST_IDLE;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_DATA: begin
        if (col_hit) begin
          st_d    = ST_IDLE;
          abort_d = 1'b1;
        end else if (!hi_q) begin
          hi_d = 1'b1;
        end else if (last_q) begin
          st_d = ST_IDLE;
        end else if (s_valid && !s_sof) begin
          s_ready = 1'b1;
          load_en = 1'b1;
        end else begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (load_en) begin
      hi_d   = 1'b0;
      last_d = s_eof;
    end
  end

  assign byte_d = load_en ? s_data : byte_q;

  // registered output decode of the next state
  always_comb begin
    txen_d = (st_d != ST_IDLE);
    unique case (st_d)
      ST_PRE:  txd_d = (cnt_d == CNT_LAST) ? NIB_SFD : NIB_PRE;
      ST_DATA: txd_d = hi_d ? byte_d[7:4] : byte_d[3:0];
      default: txd_d = '0;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      hi_q    <= 1'b0;
      last_q  <= 1'b0;
      txd_q   <= '0;
      txen_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      hi_q    <= hi_d;
      last_q  <= last_d;
      txd_q   <= txd_d;
      txen_q  <= txen_d;
      abort_q <= abort_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       byte_q <= '0;
    else if (load_en) byte_q <= byte_d;
  end

  assign txd       = txd_q;
  assign txen      = txen_q;
  assign col_abort = abort_q;

  AST_IDLE_TXD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !txen_q |-> (txd_q == '0)); // R11
  AST_FIRST_NIB_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txen_q) |-> (txd_q == NIB_PRE)); // R2
  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> s_valid); // R5
  AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q |=> !abort_q); // R8
  AST_ABORT_TXEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q |-> !txen_q); // R8
  AST_NO_START_IN_COL: assert property (@(posedge clk) disable iff (!rst_n)
    (col_sync && !full_duplex && !txen_q) |=> !txen_q); // R9
  AST_FD_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(full_duplex) |-> !abort_q); // R10
endmodule

// File: rtl/mii_nibble_tx.sv
module mii_nibble_tx #(
  parameter int PRE_BYTES   = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic       tx_clk,
  input  logic       tx_rst_n,
  input  logic       full_duplex,
  input  logic       col_in,
  input  logic       s_valid,
  output logic       s_ready,
  input  logic [7:0] s_data,
  input  logic       s_sof,
  input  logic       s_eof,
  output logic [3:0] txd,
  output logic       txen,
  output logic       col_abort
);
  logic rst_n;
  logic col_sync;

  mnt_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (tx_clk),
    .arst_n (tx_rst_n),
    .rst_n  (rst_n)
  );

  mnt_sync #(.STAGES(SYNC_STAGES)) u_col_sync (
    .clk     (tx_clk),
    .rst_n   (rst_n),
    .d_async (col_in),
    .q       (col_sync)
  );

  mnt_tx_ctrl #(.PRE_BYTES(PRE_BYTES)) u_ctrl (
    .clk         (tx_clk),
    .rst_n       (rst_n),
    .full_duplex (full_duplex),
    .col_sync    (col_sync),
    .s_valid     (s_valid),
    .s_data      (s_data),
    .s_sof       (s_sof),
    .s_eof       (s_eof),
    .s_ready     (s_ready),
    .txd         (txd),
    .txen        (txen),
    .col_abort   (col_abort)
  );
endmodule

// File: tb/mii_nibble_tx_bench.sv
`timescale 1ns/1ps
module mii_nibble_tx_bench;
  logic       tx_clk = 1'b0;
  logic       tx_rst_n = 1'b0;
  logic       full_duplex = 1'b1;
  logic       col_in = 1'b0;
  logic       s_valid = 1'b0;
  logic       s_ready;
  logic [7:0] s_data = 8'h00;
  logic       s_sof = 1'b0;
  logic       s_eof = 1'b0;
  logic [3:0] txd;
  logic       txen;
  logic       col_abort;

  int checks = 0;
  int errors = 0;
  bit mon_on = 1'b0;
  int col_cnt = 0;
  int exp_nib[$];
  int exp_len[$];
  int cap[$];
  logic prev_txen = 1'b0;
  logic prev_abort = 1'b0;

  always #10 tx_clk = ~tx_clk;

  mii_nibble_tx u_mii_nibble_tx (
    .tx_clk(tx_clk), .tx_rst_n(tx_rst_n), .full_duplex(full_duplex),
    .col_in(col_in), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_sof(s_sof), .s_eof(s_eof), .txd(txd), .txen(txen), .col_abort(col_abort)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // expected frame: 15 x 0x5, 0xD, then each byte low then high nibble
  task automatic expect_frame(input logic [7:0] fb[$], input bit aborted);
    for (int i = 0; i < 15; i++) exp_nib.push_back(5);
    exp_nib.push_back(13);
    foreach (fb[i]) begin
      exp_nib.push_back(int'(fb[i][3:0]));
      exp_nib.push_back(int'(fb[i][7:4]));
    end
    exp_len.push_back(aborted ? -(16 + 2*fb.size()) : (16 + 2*fb.size()));
  endtask

  // called at a negedge; returns at the negedge after the handshake edge
  task automatic xfer(input logic [7:0] d, input bit sof, input bit eof);
    bit r;
    s_valid = 1'b1; s_data = d; s_sof = sof; s_eof = eof;
    forever begin
      #5 r = s_ready;
      @(posedge tx_clk);
      @(negedge tx_clk);
      if (r) break;
    end
  endtask

  task automatic send(input logic [7:0] fb[$], input bit eof_last, input bit aborted);
    expect_frame(fb, aborted);
    foreach (fb[i]) xfer(fb[i], i == 0, eof_last && (i == fb.size() - 1));
    s_valid = 1'b0; s_sof = 1'b0; s_eof = 1'b0;
  endtask

  task automatic rand_bytes(input int n, output logic [7:0] fb[$]);
    fb = {};
    for (int i = 0; i < n; i++) fb.push_back(8'($urandom));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge tx_clk);
  endtask

  // pin monitor: rebuild frames and compare
  always @(negedge tx_clk) begin
    if (mon_on) begin
      if (!txen && txd != 4'h0) check(1'b0, "R11 txd while idle", int'(txd), 0);
      if (col_abort) col_cnt++;
      if (col_abort && prev_abort) check(1'b0, "R8 abort pulse width", 2, 1);
      if (txen) cap.push_back(int'(txd));
      if (prev_txen && !txen) begin
        if (exp_len.size() == 0) begin
          check(1'b0, "R4 unexpected frame", cap.size(), 0);
        end else begin
          int n;
          int m;
          int bad_pre;
          int bad_pay;
          n = exp_len.pop_front();
          m = (n < 0) ? -n : n;
          bad_pre = 0;
          bad_pay = 0;
          for (int i = 0; i < m; i++) begin
            int e;
            e = exp_nib.pop_front();
            if (i < cap.size() && cap[i] != e) begin
              if (i < 16) bad_pre++;
              else        bad_pay++;
            end
          end
          if (n > 0) check(cap.size() == m, "R4 txen length", cap.size(), m);
          else       check(cap.size() < m, "R8 aborted frame shorter", cap.size(), m - 1);
          check(bad_pre == 0, "R2 preamble nibbles", bad_pre, 0);
          check(bad_pay == 0, "R3 payload nibble order", bad_pay, 0);
        end
        cap = {};
      end
      prev_txen  = txen;
      prev_abort = col_abort;
    end
  end

  initial begin
    repeat (100000) @(posedge tx_clk);
    check(1'b0, "watchdog run incomplete", 0, 1);
    finish_sim();
  end

  initial begin
    logic [7:0] fb[$];
    int c0;
    int ns;
    int tx_seen;
    int rdy_seen;
    void'($urandom(32'd20240611));

    // R1 reset state
    idle(3);
    tx_rst_n = 1'b1;
    idle(5);
    check(txen == 1'b0, "R1 txen after reset", int'(txen), 0);
    check(txd == 4'h0, "R1 txd after reset", int'(txd), 0);
    check(col_abort == 1'b0, "R1 col_abort after reset", int'(col_abort), 0);
    #5 check(s_ready == 1'b0, "R1 s_ready without valid", int'(s_ready), 0);
    @(negedge tx_clk);
    mon_on = 1'b1;

    // R5 stray bytes without sof are dropped
    s_valid = 1'b1; s_data = 8'h3C; s_sof = 1'b0;
    #5 check(s_ready == 1'b1, "R5 stray byte accepted", int'(s_ready), 1);
    tx_seen = 0;
    repeat (6) begin @(negedge tx_clk); if (txen) tx_seen++; end
    check(tx_seen == 0, "R5 no txen for stray bytes", tx_seen, 0);
    s_valid = 1'b0;
    idle(3);

    // R2 R3 R4 directed single byte
    fb = {8'hA7};
    send(fb, 1'b1, 1'b0);
    idle(4);

    // R3 R4 random frames, random duplex mode
    for (int f = 0; f < 20; f++) begin
      full_duplex = 1'($urandom);
      rand_bytes(1 + int'($urandom % 12), fb);
      send(fb, 1'b1, 1'b0);
      idle(1 + int'($urandom % 4));
    end

    // R6 upstream gap truncates the frame
    full_duplex = 1'b1;
    rand_bytes(3, fb);
    send(fb, 1'b0, 1'b0);
    idle(6);

    // R7 early start-of-frame ends current frame and starts the next
    rand_bytes(2, fb);
    send(fb, 1'b0, 1'b0);
    rand_bytes(2, fb);
    send(fb, 1'b1, 1'b0);
    idle(6);

    // R9 no start while half-duplex collision is active
    full_duplex = 1'b0;
    col_in = 1'b1;
    idle(4);
    rand_bytes(2, fb);
    expect_frame(fb, 1'b0);
    s_valid = 1'b1; s_data = fb[0]; s_sof = 1'b1; s_eof = 1'b0;
    tx_seen = 0; rdy_seen = 0;
    repeat (30) begin
      #5 if (s_ready) rdy_seen++;
      if (txen) tx_seen++;
      @(negedge tx_clk);
    end
    check(tx_seen == 0, "R9 txen held off by collision", tx_seen, 0);
    check(rdy_seen == 0, "R9 sof byte not accepted", rdy_seen, 0);
    col_in = 1'b0;
    xfer(fb[0], 1'b1, 1'b0);
    xfer(fb[1], 1'b0, 1'b1);
    s_valid = 1'b0; s_sof = 1'b0; s_eof = 1'b0;
    idle(6);

    // R8 collision abort in half duplex
    c0 = col_cnt;
    rand_bytes(8, fb);
    ns = 0;
    fork
      send(fb, 1'b1, 1'b1);
      begin
        while (!txen) @(negedge tx_clk);
        idle(20);
        col_in = 1'b1;
        while (txen) begin @(negedge tx_clk); ns++; end
        idle(3);
        col_in = 1'b0;
      end
    join
    idle(6);
    check(ns == 3, "R8 txen falls on third edge", ns, 3);
    check(col_cnt - c0 == 1, "R8 one abort pulse", col_cnt - c0, 1);

    // R10 full duplex ignores collision
    full_duplex = 1'b1;
    c0 = col_cnt;
    col_in = 1'b1;
    idle(4);
    rand_bytes(6, fb);
    send(fb, 1'b1, 1'b0);
    idle(6);
    col_in = 1'b0;
    check(col_cnt == c0, "R10 no abort in full duplex", col_cnt - c0, 0);

    // R4 mixed random tail
    for (int f = 0; f < 10; f++) begin
      rand_bytes(1 + int'($urandom % 6), fb);
      send(fb, 1'b1, 1'b0);
      idle(2);
    end
    idle(10);
    check(exp_len.size() == 0, "R4 every frame observed", exp_len.size(), 0);
    check(txen == 1'b0 && txd == 4'h0, "R11 idle at end", int'(txd), 0);
    finish_sim();
  end
endmodule